// File: doc/BRIEF.md
# SMBus Control Register Target

This block is a two-wire serial target that owns a small bank of byte-wide control registers for a clock fanout buffer. A host addresses it at 7-bit address 0x6B and reads or writes the bank either one byte at a time or as a counted block of consecutive registers. Register contents drive the buffer's static controls: two output enables, an amplitude override flag and a 3-bit amplitude code.

Both bus lines are oversampled by the system clock through two-flop synchronisers. Start, repeated start and stop are recognised from SDA edges while SCL is high. SDA is driven open-drain: the block only ever asks for the line to be pulled low. The command byte that follows the address picks the access style. Bit 7 set means a single-byte access. Bit 7 clear means a block access. Bits 6:0 give the register index where the access starts.

Top module: `smb_ctrl_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0x6B (0xD6 write, 0xD7 read). For any other address it leaves SDA released for the rest of that transfer.
- R2: After reset the registers read 0x00, 0x00, 0xC0, 0x08, 0x06, 0xD8 at indices 0 to 5. The outputs are oe0=1, oe1=1, amp_prog=1 and amp_code=3'b101.
- R3: A write whose command byte has bit 7 set stores the next data byte into the register at index cmd[6:0]. The block acknowledges every byte of the transfer.
- R4: A read after a command byte with bit 7 set returns the register at index cmd[6:0], MSB first, after the repeated start and read address.
- R5: A write whose command byte has bit 7 clear takes the next byte as a count. It then stores that many data bytes at ascending indices starting at cmd[6:0]. Further data bytes are acknowledged and change nothing.
- R6: A read after a command byte with bit 7 clear first returns the current value of register 4 as the count. It then returns registers at ascending indices from cmd[6:0], for as long as the host acknowledges. After a host NACK the block releases SDA.
- R7: Indices of 6 and above are acknowledged. Writes to them change nothing, and reads from them return 0x00.
- R8: oe0 follows register 2 bit 7, oe1 follows register 2 bit 6, amp_prog follows register 5 bit 7, and amp_code follows register 5 bits 6:4.
- R9: A start or repeated start returns the block to address reception. A stop in the middle of a data byte writes nothing.
- R10: The block begins pulling SDA low only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| oe0_o | output | 1 | Enable for clock output 0 |
| oe1_o | output | 1 | Enable for clock output 1 |
| amp_prog_o | output | 1 | 1 selects the programmed amplitude |
| amp_code_o | output | 3 | Amplitude code, 000 lowest to 111 highest |

## Verification
A wrong register pointer or bit counter shows up at the ports within one byte time. The misplaced ACK slot or a shifted read-back byte is visible on SDA during the same transfer. A corrupted register shows on the enable and amplitude pins as soon as the write's final ACK clock falls, and it is confirmed by reading the register back. A protocol state that fails to recover from a start or stop shows up as missing acknowledges on the next transfer.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [6:0] DEV_ADDR = 7'h6B;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDATA, S_ACK, S_TX, S_RACK, S_IGN
  } smb_state_e;

  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      2:       return 8'hC0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[0];
  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev_q[0];
  assign scl_fall_o = ~synced[0] & prev_q[0];
  // SCL held high across the sample pair
  assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int N_REGS = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [6:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [6:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] bc_o,
  output logic       oe0_o,
  output logic       oe1_o,
  output logic       amp_prog_o,
  output logic [2:0] amp_code_o
);
  localparam logic [6:0] NREG_L = 7'(N_REGS);
  logic [7:0] bank [N_REGS];
  logic [8*N_REGS-1:0] bank_flat;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank[i] <= reg_reset(i);
      else if (wr_en_i && wr_addr_i == 7'(i)) bank[i] <= wr_data_i;
    end
    assign bank_flat[8*i +: 8] = bank[i];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < N_REGS; i++)
      if (rd_addr_i == 7'(i)) rd_data_o = bank[i];
  end

  assign bc_o       = bank[4];
  assign oe0_o      = bank[2][7];
  assign oe1_o      = bank[2][6];
  assign amp_prog_o = bank[5][7];
  assign amp_code_o = bank[5][6:4];

  // R7
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= NREG_L) |=> $stable(bank_flat));
  // R8
  amp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 7'd5) |=> (amp_code_o == $past(wr_data_i[6:4])
                                        && amp_prog_o == $past(wr_data_i[7])));
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] bc_i,
  output logic [6:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  smb_state_e state_q, nxt_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shreg_q, wr_left_q;
  logic [6:0] ptr_q;
  logic       blk_q, send_cnt_q, acked_q, sda_oe_q;
  logic       rx_state, byte_done;
  logic [7:0] tx_byte;

  assign rx_state  = state_q inside {S_ADDR, S_CMD, S_CNT, S_WDATA};
  assign byte_done = scl_fall_i && bitcnt_q == 4'd8;
  assign tx_byte   = send_cnt_q ? bc_i : rd_data_i;
  assign wr_en_o   = byte_done && state_q == S_WDATA && wr_left_q != 8'd0;
  assign wr_data_o = shreg_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; nxt_q <= S_IDLE; bitcnt_q <= '0; shreg_q <= '0;
      wr_left_q <= '0; ptr_q <= '0; blk_q <= 1'b0; send_cnt_q <= 1'b0;
      acked_q <= 1'b0; sda_oe_q <= 1'b0;
    end else if (start_i) begin
      state_q <= S_ADDR; bitcnt_q <= '0; sda_oe_q <= 1'b0;
    end else if (stop_i) begin
      state_q <= S_IDLE; bitcnt_q <= '0; sda_oe_q <= 1'b0;
    end else if (scl_rise_i) begin
      if (rx_state) begin
        shreg_q  <= {shreg_q[6:0], sda_i};
        bitcnt_q <= bitcnt_q + 4'd1;
      end else if (state_q == S_TX) begin
        bitcnt_q <= bitcnt_q + 4'd1;
      end else if (state_q == S_RACK) begin
        acked_q <= ~sda_i;
      end
    end else if (scl_fall_i) begin
      unique case (state_q)
        S_ADDR: if (byte_done) begin
          if (shreg_q[7:1] == DEV_ADDR) begin
            state_q    <= S_ACK;
            sda_oe_q   <= 1'b1;
            nxt_q      <= shreg_q[0] ? S_TX : S_CMD;
            send_cnt_q <= shreg_q[0] & blk_q;
          end else begin
            state_q <= S_IGN;
          end
        end
        S_CMD: if (byte_done) begin
          state_q   <= S_ACK; sda_oe_q <= 1'b1;
          ptr_q     <= shreg_q[6:0];
          blk_q     <= ~shreg_q[7];
          wr_left_q <= 8'd1;
          nxt_q     <= shreg_q[7] ? S_WDATA : S_CNT;
        end
        S_CNT: if (byte_done) begin
          state_q <= S_ACK; sda_oe_q <= 1'b1;
          wr_left_q <= shreg_q; nxt_q <= S_WDATA;
        end
        S_WDATA: if (byte_done) begin
          state_q <= S_ACK; sda_oe_q <= 1'b1; nxt_q <= S_WDATA;
          if (wr_left_q != 8'd0) begin
            ptr_q     <= ptr_q + 7'd1;
            wr_left_q <= wr_left_q - 8'd1;
          end
        end
        S_ACK: begin
          bitcnt_q <= '0;
          state_q  <= nxt_q;
          if (nxt_q == S_TX) begin
            shreg_q    <= tx_byte;
            sda_oe_q   <= ~tx_byte[7];
            send_cnt_q <= 1'b0;
            if (!send_cnt_q) ptr_q <= ptr_q + 7'd1;
          end else begin
            sda_oe_q <= 1'b0;
          end
        end
        S_TX: begin
          if (byte_done) begin
            state_q <= S_RACK; sda_oe_q <= 1'b0;
          end else begin
            shreg_q  <= {shreg_q[6:0], 1'b0};
            sda_oe_q <= ~shreg_q[6];
          end
        end
        S_RACK: begin
          bitcnt_q <= '0;
          if (acked_q) begin
            state_q  <= S_TX;
            shreg_q  <= tx_byte;
            sda_oe_q <= ~tx_byte[7];
            if (!send_cnt_q) ptr_q <= ptr_q + 7'd1;
            send_cnt_q <= 1'b0;
          end else begin
            state_q <= S_IGN;
          end
        end
        default: ;
      endcase
    end
  end

  // R10
  pull_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_i);
  // R9
  start_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == S_ADDR && bitcnt_q == 4'd0 && !sda_oe_q));
  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == $past(ptr_q) + 7'd1);
  // R6
  tx_bitcnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_TX |-> bitcnt_q <= 4'd8);
endmodule

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs #(
  parameter int N_REGS      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       oe0_o,
  output logic       oe1_o,
  output logic       amp_prog_o,
  output logic [2:0] amp_code_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] ptr;
  logic       wr_en;
  logic [7:0] wr_data, rd_data, bc;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_target_fsm u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .bc_i(bc), .ptr_o(ptr),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_oe_o(sda_oe_o)
  );

  smb_reg_bank #(.N_REGS(N_REGS)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(ptr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .rd_data_o(rd_data), .bc_o(bc),
    .oe0_o, .oe1_o, .amp_prog_o, .amp_code_o
  );
endmodule

// File: tb/tb_smb_ctrl_regs.sv
module tb_smb_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NVEC = 10;
  // {index, data written, expected read-back}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'h5A, 8'h5A}, {8'h01, 8'hA5, 8'hA5}, {8'h02, 8'h00, 8'h00},
    {8'h02, 8'h80, 8'h80}, {8'h02, 8'h40, 8'h40}, {8'h05, 8'h30, 8'h30},
    {8'h05, 8'hF0, 8'hF0}, {8'h03, 8'h3C, 8'h3C}, {8'h09, 8'hFF, 8'h00},
    {8'h7F, 8'h12, 8'h00}};

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_oe, oe0, oe1, amp_prog;
  logic [2:0] amp_code;
  logic sda_line;
  int n_tests = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  smb_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .oe0_o(oe0), .oe1_o(oe1),
    .amp_prog_o(amp_prog), .amp_code_o(amp_code)
  );

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start(); sda_m = 1; scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_rstart(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq(); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    sda_m = 1; wq(); scl = 1; wq(); ack = !sda_line; wq(); scl = 0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1; wq(); b[i] = sda_line; wq(); scl = 0;
    end
    wq(); sda_m = nack; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic byte_write(input logic [7:0] idx, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(8'hD6, a0); send_byte(8'h80 | idx, a1); send_byte(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_read(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hD6, a); send_byte(8'h80 | idx, a);
    bus_rstart(); send_byte(8'hD7, a); recv_byte(1'b1, d); bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [7:0] d, cnt;
    logic [7:0] rst_exp [6];
    rst_exp = '{8'h00, 8'h00, 8'hC0, 8'h08, 8'h06, 8'hD8};
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2 reset outputs
    check("R2 outputs", {4'b0, oe0, oe1, amp_prog, 1'b0}, 8'h0E);
    check("R2 amp_code", {5'b0, amp_code}, 8'h05);

    // R6 / R2 block read of reset contents
    bus_start(); send_byte(8'hD6, a); send_byte(8'h00, a);
    bus_rstart(); send_byte(8'hD7, a);
    recv_byte(1'b0, cnt);
    check("R6 count", cnt, 8'h06);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i == 5, d);
      check("R2 reset value", d, rst_exp[i]);
    end
    bus_stop();
    check("R6 released after nack", {7'b0, sda_oe}, 8'h00);

    // R3 R4 R7 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      byte_write(VEC[v][23:16], VEC[v][15:8], ok);
      check("R3 ack", {7'b0, ok}, 8'h01);
      byte_read(VEC[v][23:16], d);
      check((VEC[v][23:16] > 8'h05) ? "R7 read" : "R4 read", d, VEC[v][7:0]);
      if (VEC[v][23:16] == 8'h02)
        check("R8 enables", {6'b0, oe0, oe1}, {6'b0, VEC[v][7:6]});
      if (VEC[v][23:16] == 8'h05)
        check("R8 amplitude", {4'b0, amp_prog, amp_code}, {4'b0, VEC[v][7:4]});
    end

    // R1 foreign address
    bus_start(); send_byte(8'hA0, a);
    check("R1 foreign nack", {7'b0, a}, 8'h00);
    send_byte(8'h80, a);
    check("R1 stays released", {7'b0, a}, 8'h00);
    bus_stop();

    // R5 block write of 3 with one extra byte
    bus_start(); send_byte(8'hD6, a); send_byte(8'h00, a); send_byte(8'h03, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    send_byte(8'h44, a);
    check("R5 extra acked", {7'b0, a}, 8'h01);
    bus_stop();
    byte_read(8'h00, d); check("R5 reg0", d, 8'h11);
    byte_read(8'h01, d); check("R5 reg1", d, 8'h22);
    byte_read(8'h02, d); check("R5 reg2", d, 8'h33);
    byte_read(8'h03, d); check("R5 extra ignored", d, 8'h3C);

    // R9 stop in mid data byte
    bus_start(); send_byte(8'hD6, a); send_byte(8'h80, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    bus_stop();
    byte_read(8'h00, d); check("R9 partial ignored", d, 8'h11);

    // R9 repeated start abandons a write, then a fresh address is taken
    bus_start(); send_byte(8'hD6, a); send_byte(8'h81, a);
    bus_rstart(); send_byte(8'hD6, a);
    check("R9 rearm ack", {7'b0, a}, 8'h01);
    bus_stop();

    // R6 programmed count and start index
    byte_write(8'h04, 8'h02, ok);
    bus_start(); send_byte(8'hD6, a); send_byte(8'h01, a);
    bus_rstart(); send_byte(8'hD7, a);
    recv_byte(1'b0, cnt); check("R6 programmed count", cnt, 8'h02);
    recv_byte(1'b0, d);   check("R6 first", d, 8'h22);
    recv_byte(1'b1, d);   check("R6 second", d, 8'h33);
    bus_stop();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule